// File: doc/BRIEF.md
# Promotable Priority Interrupt Controller

This block gathers interrupt requests from a set of maskable sources and one non-maskable source. It then presents one winner at a time to a processor. Each source raises a one-cycle event pulse, and that pulse latches a sticky pending flag. The flag is cleared only by a dedicated clear strobe, which the service routine normally issues. Every maskable source carries a local enable. A single global mask bit shuts out all maskable sources at once. Each source has a fixed vector address, and by default the source with the larger vector wins.

Software can move any one maskable source to the top of the order by writing the low byte of that source's vector into a promotion register. All other sources keep their order relative to each other. The non-maskable request stays above everything. The processor sees a valid flag and the winning vector. It takes the request by pulsing a take input. The block answers with a registered acknowledge and sets the global mask, so that a second maskable request cannot nest inside the first.

Top module: `prio_intc`

## Requirements
- R1: A source's pending flag is set by its event pulse and stays set until its clear strobe. When a pulse and a clear strobe arrive in the same cycle, the flag ends up set. The non-maskable flag behaves the same way with its own pulse and clear inputs.
- R2: Maskable source i has vector VEC_BASE + 2*i. The non-maskable source has vector NMI_VEC.
- R3: The global mask bit (1 = maskable requests blocked) is 1 after reset. The set request drives it to 1 and the clear request drives it to 0. If both arrive in the same cycle, set wins.
- R4: A maskable source is eligible only when its flag is set, its local enable is 1 and the global mask is 0.
- R5: A pending non-maskable request is presented regardless of the mask and the local enables, and it outranks every maskable source, including a promoted one.
- R6: With no promotion match among the eligible sources, the eligible source with the highest vector address wins.
- R7: When the promotion register equals bits [7:0] of an eligible source's vector, that source wins. Otherwise the default order of R6 applies to the rest.
- R8: A promotion value that matches no source leaves pure vector ordering in force. After reset, the promotion register holds bits [7:0] of the highest source vector.
- R9: A take while irqValid is high sets the mask to 1 on the next cycle and produces a one-cycle irqAck on the next cycle. A take while irqValid is low has no effect.
- R10: With no eligible request, irqValid is 0 and irqVector is 0. The outputs depend combinationally on the registered flags, the mask, the promotion register and the local enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtPulse | input | NUM_SRC | One-cycle event pulse per maskable source |
| clrStrobe | input | NUM_SRC | Clear strobe per maskable source |
| localEn | input | NUM_SRC | Local enable per maskable source |
| nmiPulse | input | 1 | Non-maskable event pulse |
| nmiClr | input | 1 | Non-maskable flag clear |
| maskSetReq | input | 1 | Drive global mask to blocking |
| maskClrReq | input | 1 | Drive global mask to permitting |
| promoWr | input | 1 | Write strobe for the promotion register |
| promoData | input | 8 | Vector low byte to promote |
| irqTake | input | 1 | Processor takes the presented request |
| irqValid | output | 1 | A request is presented |
| irqVector | output | VEC_W | Vector address of the winner |
| irqAck | output | 1 | Registered acknowledge of a take |
| maskState | output | 1 | Current global mask bit |

## Verification
The bench builds the block with eight sources, VEC_BASE 16'hFFE0 and NMI_VEC 16'hFFFC. With only eight sources, random event pulses leave several flags pending together most of the time. That makes the promotion path, promotion of a source that is pending but not enabled, and the fall back to default order all common. Promotion bytes are drawn mostly from the eight real vector low bytes, with non-matching bytes mixed in. This reaches both the promoted case and the no-match case. The random phase also drives same-cycle set and clear, mask set and clear collisions, and takes issued while nothing is valid.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // Strobes and values passed from control to datapath each cycle.
  typedef struct packed {
    logic       gateOpen;   // global mask permits maskable requests
    logic       loadPromo;  // load promotion register this cycle
    logic [7:0] promoVal;   // value to load
  } ctrlStrobe_t;

endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        maskSetReq,
  input  logic        maskClrReq,
  input  logic        promoWr,
  input  logic [7:0]  promoData,
  input  logic        grantTaken,
  output ctrlStrobe_t strb,
  output logic        maskState,
  output logic        irqAck
);

  // Global mask: blocking after reset. A taken grant or a set request
  // forces blocking; a clear request permits only if neither is present.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskState <= 1'b1;
      irqAck    <= 1'b0;
    end else begin
      if (grantTaken || maskSetReq) begin
        maskState <= 1'b1;
      end else if (maskClrReq) begin
        maskState <= 1'b0;
      end
      irqAck <= grantTaken;
    end
  end

  always_comb begin
    strb.gateOpen  = !maskState;
    strb.loadPromo = promoWr;
    strb.promoVal  = promoData;
  end

endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int                 NUM_SRC  = 16,
  parameter int                 VEC_W    = 16,
  parameter logic [VEC_W-1:0]   VEC_BASE = 16'hFFC0,
  parameter logic [VEC_W-1:0]   NMI_VEC  = 16'hFFFC
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic [NUM_SRC-1:0] clrStrobe,
  input  logic [NUM_SRC-1:0] localEn,
  input  logic               nmiPulse,
  input  logic               nmiClr,
  input  ctrlStrobe_t        strb,
  output logic               irqValid,
  output logic [VEC_W-1:0]   irqVector
);

  localparam int               IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [VEC_W-1:0] TOP_VEC   = VEC_BASE + VEC_W'(2 * (NUM_SRC - 1));
  localparam logic [7:0]       PROMO_RST = TOP_VEC[7:0];

  logic [NUM_SRC-1:0] pendFlag;
  logic [NUM_SRC-1:0] promoHit;
  logic [NUM_SRC-1:0] eligible;
  logic               nmiFlag;
  logic [7:0]         promoReg;

  // Per-source sticky flags and promotion match decode.
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam logic [VEC_W-1:0] SRC_VEC = VEC_BASE + VEC_W'(2 * g);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendFlag[g] <= 1'b0;
      end else if (evtPulse[g]) begin
        pendFlag[g] <= 1'b1;
      end else if (clrStrobe[g]) begin
        pendFlag[g] <= 1'b0;
      end
    end

    assign promoHit[g] = (SRC_VEC[7:0] == promoReg);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nmiFlag  <= 1'b0;
      promoReg <= PROMO_RST;
    end else begin
      if (nmiPulse) begin
        nmiFlag <= 1'b1;
      end else if (nmiClr) begin
        nmiFlag <= 1'b0;
      end
      if (strb.loadPromo) begin
        promoReg <= strb.promoVal;
      end
    end
  end

  assign eligible = pendFlag & localEn & {NUM_SRC{strb.gateOpen}};

  logic [IDX_W-1:0] defIdx;
  logic [IDX_W-1:0] promoIdx;
  logic [IDX_W-1:0] winIdx;
  logic             anyElig;
  logic             promoElig;

  // Default order: highest index (highest vector) scanned last wins.
  always_comb begin
    defIdx   = '0;
    promoIdx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (eligible[i]) begin
        defIdx = IDX_W'(i);
      end
      if (eligible[i] && promoHit[i]) begin
        promoIdx = IDX_W'(i);
      end
    end
  end

  assign anyElig   = |eligible;
  assign promoElig = |(eligible & promoHit);
  assign winIdx    = promoElig ? promoIdx : defIdx;

  always_comb begin
    if (nmiFlag) begin
      irqValid  = 1'b1;
      irqVector = NMI_VEC;
    end else if (anyElig) begin
      irqValid  = 1'b1;
      irqVector = VEC_BASE + (VEC_W'(winIdx) << 1);
    end else begin
      irqValid  = 1'b0;
      irqVector = '0;
    end
  end

endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int                 NUM_SRC  = 16,
  parameter int                 VEC_W    = 16,
  parameter logic [VEC_W-1:0]   VEC_BASE = 16'hFFC0,
  parameter logic [VEC_W-1:0]   NMI_VEC  = 16'hFFFC
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic [NUM_SRC-1:0] clrStrobe,
  input  logic [NUM_SRC-1:0] localEn,
  input  logic               nmiPulse,
  input  logic               nmiClr,
  input  logic               maskSetReq,
  input  logic               maskClrReq,
  input  logic               promoWr,
  input  logic [7:0]         promoData,
  input  logic               irqTake,
  output logic               irqValid,
  output logic [VEC_W-1:0]   irqVector,
  output logic               irqAck,
  output logic               maskState
);

  ctrlStrobe_t strb;
  logic        grantTaken;

  assign grantTaken = irqTake & irqValid;

  intc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .maskSetReq(maskSetReq),
    .maskClrReq(maskClrReq),
    .promoWr   (promoWr),
    .promoData (promoData),
    .grantTaken(grantTaken),
    .strb      (strb),
    .maskState (maskState),
    .irqAck    (irqAck)
  );

  intc_datapath #(
    .NUM_SRC (NUM_SRC),
    .VEC_W   (VEC_W),
    .VEC_BASE(VEC_BASE),
    .NMI_VEC (NMI_VEC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .evtPulse (evtPulse),
    .clrStrobe(clrStrobe),
    .localEn  (localEn),
    .nmiPulse (nmiPulse),
    .nmiClr   (nmiClr),
    .strb     (strb),
    .irqValid (irqValid),
    .irqVector(irqVector)
  );

endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int                 NUM_SRC  = 16,
  parameter int                 VEC_W    = 16,
  parameter logic [VEC_W-1:0]   VEC_BASE = 16'hFFC0,
  parameter logic [VEC_W-1:0]   NMI_VEC  = 16'hFFFC
) (
  input logic             clk,
  input logic             rstN,
  input logic             irqValid,
  input logic [VEC_W-1:0] irqVector,
  input logic             irqTake,
  input logic             irqAck,
  input logic             maskState,
  input logic             maskSetReq
);

  localparam logic [VEC_W-1:0] TOP_VEC = VEC_BASE + VEC_W'(2 * (NUM_SRC - 1));

  // R9: taking a presented request blocks maskables and acknowledges.
  a_r9_take_masks: assert property (@(posedge clk) disable iff (!rstN)
    (irqTake && irqValid) |=> (maskState && irqAck));

  // R9: an acknowledge only follows a valid take.
  a_r9_ack_origin: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |-> $past(irqTake && irqValid));

  // R5: while maskables are blocked, only the non-maskable vector appears.
  a_r5_masked_only_nmi: assert property (@(posedge clk) disable iff (!rstN)
    (irqValid && maskState) |-> (irqVector == NMI_VEC));

  // R2: a presented vector is the non-maskable one or an even in-range source vector.
  a_r2_vector_legal: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> ((irqVector == NMI_VEC) ||
                  (irqVector >= VEC_BASE && irqVector <= TOP_VEC &&
                   irqVector[0] == VEC_BASE[0])));

  // R10: idle outputs read zero.
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !irqValid |-> (irqVector == '0));

  // R3: a set request always leaves the mask blocking.
  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    maskSetReq |=> maskState);

endmodule

bind prio_intc intc_checker #(
  .NUM_SRC (NUM_SRC),
  .VEC_W   (VEC_W),
  .VEC_BASE(VEC_BASE),
  .NMI_VEC (NMI_VEC)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .irqValid  (irqValid),
  .irqVector (irqVector),
  .irqTake   (irqTake),
  .irqAck    (irqAck),
  .maskState (maskState),
  .maskSetReq(maskSetReq)
);

// File: tb/prio_intc_bench.sv
module prio_intc_bench;

  localparam int          CLK_PERIOD = 10;
  localparam int          N          = 8;
  localparam int          VW         = 16;
  localparam logic [15:0] BASE       = 16'hFFE0;
  localparam logic [15:0] NMIV       = 16'hFFFC;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  evtPulse = '0;
  logic [N-1:0]  clrStrobe = '0;
  logic [N-1:0]  localEn = '0;
  logic          nmiPulse = 1'b0;
  logic          nmiClr = 1'b0;
  logic          maskSetReq = 1'b0;
  logic          maskClrReq = 1'b0;
  logic          promoWr = 1'b0;
  logic [7:0]    promoData = '0;
  logic          irqTake = 1'b0;
  logic          irqValid;
  logic [VW-1:0] irqVector;
  logic          irqAck;
  logic          maskState;

  always #(CLK_PERIOD / 2) clk = ~clk;

  prio_intc #(
    .NUM_SRC(N), .VEC_W(VW), .VEC_BASE(BASE), .NMI_VEC(NMIV)
  ) u_prio_intc (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .clrStrobe(clrStrobe),
    .localEn(localEn), .nmiPulse(nmiPulse), .nmiClr(nmiClr),
    .maskSetReq(maskSetReq), .maskClrReq(maskClrReq), .promoWr(promoWr),
    .promoData(promoData), .irqTake(irqTake), .irqValid(irqValid),
    .irqVector(irqVector), .irqAck(irqAck), .maskState(maskState)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Reference model state.
  logic [N-1:0] mFlags = '0;
  logic         mNmi = 1'b0;
  logic         mMask = 1'b1;
  logic [7:0]   mPromo = 8'hEE;  // R8: low byte of BASE + 2*(N-1)
  logic         mAck = 1'b0;

  function automatic logic [15:0] srcVec(int i);
    return BASE + 16'(2 * i);
  endfunction

  function automatic logic [N-1:0] eligNow();
    return mFlags & localEn & {N{!mMask}};
  endfunction

  function automatic logic [15:0] expVector();
    logic [N-1:0] el = eligNow();
    logic [15:0]  tmp;
    if (mNmi) return NMIV;
    for (int i = 0; i < N; i++) begin
      tmp = srcVec(i);
      if (el[i] && tmp[7:0] == mPromo) return tmp;
    end
    for (int i = N - 1; i >= 0; i--) begin
      if (el[i]) return srcVec(i);
    end
    return '0;
  endfunction

  function automatic string expTag();
    logic [N-1:0] el = eligNow();
    logic [15:0]  tmp;
    if (mNmi) return "R5";
    if (el == '0) return "R10";
    for (int i = 0; i < N; i++) begin
      tmp = srcVec(i);
      if (el[i] && tmp[7:0] == mPromo) return "R7";
    end
    return "R6";
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Inputs are already driven (at a falling edge). Compare, clock, update model.
  task automatic step();
    logic [15:0] ev;
    logic        grant;
    #1;
    ev = expVector();
    check(expTag(), 32'(irqVector), 32'(ev), "irqVector");
    check(expTag(), 32'(irqValid), 32'(mNmi || eligNow() != '0), "irqValid");
    check("R3", 32'(maskState), 32'(mMask), "maskState");
    check("R9", 32'(irqAck), 32'(mAck), "irqAck");
    grant = irqTake && (mNmi || eligNow() != '0);
    @(posedge clk);
    mFlags = (mFlags & ~clrStrobe) | evtPulse;   // R1: set wins
    if (nmiPulse) mNmi = 1'b1;
    else if (nmiClr) mNmi = 1'b0;
    if (grant || maskSetReq) mMask = 1'b1;
    else if (maskClrReq) mMask = 1'b0;
    if (promoWr) mPromo = promoData;
    mAck = grant;
    @(negedge clk);
  endtask

  task automatic idleIn();
    evtPulse = '0; clrStrobe = '0; nmiPulse = 0; nmiClr = 0;
    maskSetReq = 0; maskClrReq = 0; promoWr = 0; irqTake = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    localEn = '1;
    // R3 R10: reset state.
    step();
    // R4: flag pending but mask blocking -> no request.
    idleIn(); evtPulse[2] = 1; step();
    idleIn(); step();
    // R3: clear mask; R6 source 2 presented.
    idleIn(); maskClrReq = 1; step();
    idleIn(); step();
    // R6: higher vector wins.
    idleIn(); evtPulse[5] = 1; step();
    idleIn(); step();
    // R4: local enable off drops source 5.
    idleIn(); localEn[5] = 0; step();
    localEn = '1;
    // R7: promote source 1 above 5.
    idleIn(); evtPulse[1] = 1; promoWr = 1; promoData = 8'hE2; step();
    idleIn(); step();
    // R8: unmatched promotion byte -> default order.
    idleIn(); promoWr = 1; promoData = 8'h00; step();
    idleIn(); step();
    // R5: non-maskable wins, also with mask blocking.
    idleIn(); nmiPulse = 1; step();
    idleIn(); maskSetReq = 1; step();
    idleIn(); step();
    // R9: take sets mask and acks.
    idleIn(); maskClrReq = 1; step();
    idleIn(); irqTake = 1; nmiClr = 1; step();
    idleIn(); step();
    // R1: clear and event on the same cycle leaves flag set.
    idleIn(); maskClrReq = 1; step();
    idleIn(); clrStrobe[5] = 1; evtPulse[5] = 1; step();
    idleIn(); step();
    // R3: set and clear together -> set wins.
    idleIn(); maskSetReq = 1; maskClrReq = 1; step();
    // R9: take with nothing valid has no effect.
    idleIn(); clrStrobe = '1; maskClrReq = 1; step();
    idleIn(); irqTake = 1; step();
    idleIn(); step();

    // Random phase.
    for (int c = 0; c < 4000; c++) begin
      idleIn();
      for (int i = 0; i < N; i++) begin
        evtPulse[i]  = ($urandom_range(0, 9) == 0);
        clrStrobe[i] = ($urandom_range(0, 7) == 0);
      end
      if ($urandom_range(0, 15) == 0) localEn = N'($urandom);
      nmiPulse   = ($urandom_range(0, 60) == 0);
      nmiClr     = ($urandom_range(0, 5) == 0);
      maskSetReq = ($urandom_range(0, 20) == 0);
      maskClrReq = ($urandom_range(0, 4) == 0);
      irqTake    = ($urandom_range(0, 6) == 0);
      if ($urandom_range(0, 12) == 0) begin
        promoWr = 1;
        if ($urandom_range(0, 3) == 0) promoData = 8'($urandom);
        else promoData = 8'(BASE[7:0] + 8'(2 * $urandom_range(0, N - 1)));
      end
      step();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule